// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block is the digital half of a processor supervisor. It watches a synchronous supply-good flag, which stands for the result of an analog supply-versus-threshold comparison made elsewhere. It also watches a watchdog service line. From these two inputs it drives a single reset output whose active level is chosen by a parameter. A reset pulse of fixed width follows power-up, any supply dip, and any watchdog time-out. The block also reports a two-bit code that tells why the last reset happened.

All timing is counted in cycles of a slow tick-enable input. The pulse width and the watchdog window are parameters given in ticks. With a 1 ms tick, the defaults give a 200 ms pulse and a 1.6 s window. The service line passes through a synchronizer. Either a rising or a falling edge on it restarts the window. A strap input marks the service line as unconnected, and while it is set the watchdog never expires. A line that is stuck at one level produces a reset train whose period is the window plus the pulse width.

Top module: `supv_top`

## Requirements
- R1: The asynchronous power-on clear (porN low) asserts reset and sets the cause code to 00 (power-up). After porN is released, reset is removed only once PULSE_TICKS ticks have been counted with supply-good high. The cause code stays 00 even when supply-good is low at power-on.
- R2: A low supply-good asserts reset at the next clock edge. Reset stays asserted for every cycle that supply-good is low. A fall of supply-good that was high at the previous edge sets the cause code to 01 (brown-out).
- R3: When supply-good returns high, reset stays asserted until PULSE_TICKS further ticks have been counted, and is released on the edge that counts the last of them.
- R4: While reset is released, PULSE_TICKS is not involved. If WD_TICKS ticks pass without a service event, reset asserts on the edge of the last tick, and the cause code becomes 10 (watchdog).
- R5: A level change of either direction on wdKick is a service event. It clears the window on the third clock edge after the change, because of two synchronizer flops and one edge-detect flop. A clear that lands on the same edge as the expiry wins over the expiry.
- R6: After a watchdog pulse ends, a fresh window of WD_TICKS ticks begins. A service line that never changes therefore gives reset pulses of PULSE_TICKS ticks, separated by WD_TICKS ticks of release.
- R7: While wdFloat is 1, every cycle counts as a service event, and the watchdog never asserts reset.
- R8: Service edges that fall entirely inside a reset pulse have no effect, because the window counter is held cleared during reset. The next time-out still comes exactly WD_TICKS ticks after release.
- R9: With ACTIVE_LOW=1 the reset output is low while reset is asserted. With ACTIVE_LOW=0 it is high while reset is asserted.
- R10: The counters advance only on clock edges where tickEn is 1. Durations are measured in ticks, not clock cycles.
- R11: The cause code never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on clear, active low |
| tickEn | input | 1 | Time-base enable, one tick per high cycle |
| supplyOk | input | 1 | Synchronous supply-good flag |
| wdKick | input | 1 | Watchdog service line, toggled by software |
| wdFloat | input | 1 | Service line marked unconnected; suppresses time-out |
| rstOut | output | 1 | Reset output, polarity per ACTIVE_LOW |
| rstCause | output | 2 | Last reset cause: 00 power-up, 01 brown-out, 10 watchdog |

## Verification
A drop of supply-good shows on the reset output at the first edge after it. Release comes on the edge that counts the PULSE_TICKS-th tick after supply returns. A time-out comes on the edge of the WD_TICKS-th tick after release. A change on the service line acts three edges after it is driven. The bench drives every input just after a falling clock edge and reads the outputs on later falling edges. It counts the ticks it has driven into each interval, so each expected length is a plain tick count. The service-timing sweep moves the toggle across every cycle of the window. The expected outcome is computed from the three-edge latency: a toggle at cycle d after release prevents the time-out only when d is at most WD_TICKS-3.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    CAUSE_PWR   = 2'b00,
    CAUSE_BROWN = 2'b01,
    CAUSE_WDOG  = 2'b10
  } causeT;

  // Strobes from control to datapath: hold each counter cleared.
  typedef struct packed {
    logic pulseClr;
    logic wdClr;
  } strobeT;
endpackage

// File: rtl/supv_dp.sv
module supv_dp
  import supv_pkg::*;
#(
  parameter int PULSE_TICKS = 200,
  parameter int WD_TICKS    = 1600,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   porN,
  input  logic   tickEn,
  input  logic   wdKick,
  input  logic   wdFloat,
  input  strobeT strb,
  output logic   pulseDone,
  output logic   wdExpire
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam int WW = $clog2(WD_TICKS + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);
  localparam logic [WW-1:0] WD_LAST    = WW'(WD_TICKS - 1);
  localparam int SH = SYNC_STAGES + 1;

  logic [SH-1:0] kickSh;
  logic [PW-1:0] pulseCnt;
  logic [WW-1:0] wdCnt;
  logic kickEdge, kick;

  // Synchronizer stages followed by one flop for edge detection.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) kickSh <= '0;
    else       kickSh <= {kickSh[SH-2:0], wdKick};
  end

  assign kickEdge  = kickSh[SH-1] ^ kickSh[SH-2];
  assign kick      = kickEdge | wdFloat;
  assign pulseDone = !strb.pulseClr && tickEn && (pulseCnt == PULSE_LAST);
  assign wdExpire  = !strb.wdClr && !kick && tickEn && (wdCnt == WD_LAST);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              pulseCnt <= '0;
    else if (strb.pulseClr) pulseCnt <= '0;
    else if (tickEn)        pulseCnt <= pulseDone ? '0 : pulseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                   wdCnt <= '0;
    else if (strb.wdClr || kick) wdCnt <= '0;
    else if (tickEn)             wdCnt <= wdExpire ? '0 : wdCnt + 1'b1;
  end

  assert_pulse_range_R3: assert property (@(posedge clk) disable iff (!porN)
    pulseCnt <= PULSE_LAST);
  assert_wd_range_R4: assert property (@(posedge clk) disable iff (!porN)
    wdCnt <= WD_LAST);
  // R8: no count is carried across a reset pulse
  assert_wd_held_R8: assert property (@(posedge clk) disable iff (!porN)
    strb.wdClr |=> (wdCnt == '0));
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic   clk,
  input  logic   porN,
  input  logic   supplyOk,
  input  logic   pulseDone,
  input  logic   wdExpire,
  output strobeT strb,
  output logic   inReset,
  output causeT  cause
);
  logic supplyPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      inReset    <= 1'b1;
      cause      <= CAUSE_PWR;
      supplyPrev <= 1'b0;
    end else begin
      supplyPrev <= supplyOk;
      if (!supplyOk) begin
        inReset <= 1'b1;
        if (supplyPrev) cause <= CAUSE_BROWN;
      end else if (inReset) begin
        if (pulseDone) inReset <= 1'b0;
      end else if (wdExpire) begin
        inReset <= 1'b1;
        cause   <= CAUSE_WDOG;
      end
    end
  end

  always_comb begin
    strb.pulseClr = !supplyOk || !inReset;
    strb.wdClr    = !supplyOk || inReset;
  end

  assert_brownout_R2: assert property (@(posedge clk) disable iff (!porN)
    !supplyOk |=> inReset);
  assert_release_supply_R3: assert property (@(posedge clk) disable iff (!porN)
    $fell(inReset) |-> $past(supplyOk));
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!porN)
    $rose(inReset) |-> (cause != CAUSE_PWR));
  assert_cause_legal_R11: assert property (@(posedge clk) disable iff (!porN)
    cause != 2'b11);
endmodule

// File: rtl/supv_top.sv
module supv_top
  import supv_pkg::*;
#(
  parameter int PULSE_TICKS = 200,
  parameter int WD_TICKS    = 1600,
  parameter bit ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       tickEn,
  input  logic       supplyOk,
  input  logic       wdKick,
  input  logic       wdFloat,
  output logic       rstOut,
  output logic [1:0] rstCause
);
  strobeT strb;
  logic pulseDone, wdExpire, inReset;
  causeT cause;

  supv_dp #(.PULSE_TICKS(PULSE_TICKS), .WD_TICKS(WD_TICKS), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .porN(porN), .tickEn(tickEn), .wdKick(wdKick), .wdFloat(wdFloat),
    .strb(strb), .pulseDone(pulseDone), .wdExpire(wdExpire)
  );

  supv_ctrl ctrl_i (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .pulseDone(pulseDone),
    .wdExpire(wdExpire), .strb(strb), .inReset(inReset), .cause(cause)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign rstOut = ~inReset;
    end else begin : g_high
      assign rstOut = inReset;
    end
  endgenerate

  assign rstCause = cause;
endmodule

// File: tb/supv_top_tb_top.sv
`timescale 1ns/1ps
module supv_top_tb_top;
  localparam int P = 5;
  localparam int W = 8;

  logic clk = 1'b0;
  logic porN = 1'b0, tickEn = 1'b1, supplyOk = 1'b1, wdKick = 1'b0, wdFloat = 1'b0;
  logic rstLo, rstHi;
  logic [1:0] causeLo, causeHi;
  int errs = 0, checks = 0, polErr = 0, tickDiv = 1, phase = 0, cyc = 0;
  int tk, cy;

  always #10 clk = ~clk;  // 50 MHz

  supv_top #(.PULSE_TICKS(P), .WD_TICKS(W), .ACTIVE_LOW(1'b1)) dut_i (
    .clk(clk), .porN(porN), .tickEn(tickEn), .supplyOk(supplyOk), .wdKick(wdKick),
    .wdFloat(wdFloat), .rstOut(rstLo), .rstCause(causeLo));
  supv_top #(.PULSE_TICKS(P), .WD_TICKS(W), .ACTIVE_LOW(1'b0)) dutHi_i (
    .clk(clk), .porN(porN), .tickEn(tickEn), .supplyOk(supplyOk), .wdKick(wdKick),
    .wdFloat(wdFloat), .rstOut(rstHi), .rstCause(causeHi));

  wire rstActive = (rstLo == 1'b0);

  // Tick generator, updated mid-phase so it is stable at both edges.
  always begin
    @(posedge clk); #5;
    phase  = (phase + 1 >= tickDiv) ? 0 : phase + 1;
    tickEn = (phase == 0);
  end

  // R9: opposite-polarity twin must always mirror the active-low output.
  always @(negedge clk) begin
    cyc++;
    if (porN && rstHi !== ~rstLo) polErr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic level, output int ticks, output int cycles);
    logic t;
    ticks = 0; cycles = 0;
    while (rstActive == level && cycles < 5000) begin
      t = tickEn;
      @(negedge clk);
      cycles++;
      if (t) ticks++;
    end
  endtask

  task automatic brownout(input int len, input string req);
    supplyOk = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk({req, " R2 asserted while supply low"}, int'(rstActive), 1);
    end
    supplyOk = 1'b1;
    measure(1'b1, tk, cy);
    chk({req, " R3 stretch ticks"}, tk, P);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset during porN", int'(rstActive), 1);
    porN = 1'b1;
    chk("R1 cause after power-on", int'(causeLo), 0);
    measure(1'b1, tk, cy);
    chk("R1 power-up pulse ticks", tk, P);

    // Stuck service line: periodic watchdog train.
    measure(1'b0, tk, cy);
    chk("R4 window ticks", tk, W);
    chk("R4 cause watchdog", int'(causeLo), 2);
    measure(1'b1, tk, cy);
    chk("R6 watchdog pulse ticks", tk, P);
    measure(1'b0, tk, cy);
    chk("R6 fresh window ticks", tk, W);

    // Toggle right at pulse start: edge lands inside the pulse.
    wdKick = ~wdKick;
    measure(1'b1, tk, cy);
    chk("R8 pulse ticks with ignored kick", tk, P);
    measure(1'b0, tk, cy);
    chk("R8 window unchanged after ignored kick", tk, W);

    // Brown-out cause and service-timing sweep.
    for (int d = 0; d <= W + 1; d++) begin
      logic seen;
      brownout(1 + d % 4, "sweep");
      chk("R2 cause brown-out", int'(causeLo), 1);
      seen = 1'b0;
      for (int j = 0; j < W; j++) begin
        if (j == d) wdKick = ~wdKick;
        @(negedge clk);
        if (rstActive) seen = 1'b1;
      end
      chk($sformatf("R5 kick at d=%0d timeout", d), int'(seen), int'(d >= W - 2));
      if (seen) chk("R4 cause after sweep timeout", int'(causeLo), 2);
    end

    // Float strap holds off the watchdog.
    brownout(2, "float");
    wdFloat = 1'b1;
    begin
      int hits = 0;
      for (int j = 0; j < 3 * W; j++) begin
        @(negedge clk);
        if (rstActive) hits++;
      end
      chk("R7 no timeout while floating", hits, 0);
    end
    wdFloat = 1'b0;

    // Slow tick: durations follow ticks, not cycles.
    tickDiv = 3;
    brownout(2, "slow tick");
    chk("R10 pulse spans multiple cycles per tick", int'(cy >= 3 * P - 2), 1);
    measure(1'b0, tk, cy);
    chk("R10 window ticks at slow tick", tk, W);
    chk("R10 window cycles at slow tick", int'(cy >= 3 * W - 2), 1);
    measure(1'b1, tk, cy);
    tickDiv = 1;

    // Power-on with supply low keeps power-up cause.
    porN = 1'b0; supplyOk = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 held with supply low", int'(rstActive), 1);
    chk("R1 cause stays power-up", int'(causeLo), 0);
    supplyOk = 1'b1;
    measure(1'b1, tk, cy);
    chk("R1 pulse after late supply", tk, P);
    chk("R11 cause legal", int'(causeLo != 2'd3), 1);

    chk("R9 polarity mirror mismatches", polErr, 0);
    chk("R9 active-high twin cause agrees", int'(causeHi), int'(causeLo));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule